// File: doc/BRIEF.md
# Paged indirect address generator

This block forms the effective address of a 16-bit register-indirect data access that may reach into a paged window. It holds two 10-bit page registers, one used by reads and one used by writes. A single move can therefore read from one page and write to another. The address is paged only when bit 15 of the pointer is 1 before modification. Pointers with bit 15 at 0 address the base data space (0x0000-0x7FFF), and no paging applies to them.

Each access picks pre- or post-modification, increment or decrement, and a byte step of 1 or a word step of 2. When a paged pointer steps past the end or the start of the window, linear-stepping modes move the page register by one and keep bit 15 set, so the paged space looks contiguous. Fixed exceptions apply at the edges of the page ranges. Wrapping modes, used for offset, modulo and bit-reversed access, keep the page and wrap inside it. The outputs are combinational: the effective address, the page it uses, the updated pointer and page, and an address-error flag. The page register is committed at the clock edge when `req_i` is high and no error is flagged.

Top module: `paged_agen`

## Requirements
- R1: After reset both page registers hold 0x001.
- R2: A pointer with bit 15 at 0 is a base-space access: `ptr_upd_o` is the pointer plus or minus the step with no page effect, `page_upd_o` equals the current page, and `addr_err_o` is 0.
- R3: A paged increment in linear mode that carries past 0xFFFF gives a page one higher and a pointer with bit 15 set and the low 15 bits of the sum.
- R4: A paged decrement in linear mode that falls below 0x8000 gives a page one lower and a pointer with bit 15 set.
- R5: `mode_i` bit 0 selects post-modify (1) or pre-modify (0), and bit 1 selects decrement (1) or increment (0). `byte_i`=1 steps by 1, and otherwise the step is 2. Pre-modify drives `ea_o`/`page_o` from the updated pointer and page. Post-modify drives them from the original pointer and current page.
- R6: With `wrap_i`=1, a crossing sets bit 15 of the pointer and leaves the page unchanged.
- R7: Linear overflow with read page 0x1FF or 0x3FF, or with write page 0x1FF, keeps the page and clears bit 15.
- R8: Linear read underflow with page 0x001 or 0x200 keeps the page and clears bit 15.
- R9: A linear read overflow at page 0x2FF moves to page 0x300, and an underflow at 0x300 moves to 0x2FF. In both cases bit 15 stays set.
- R10: A paged access whose selected page is 0x000 raises `addr_err_o`.
- R11: A paged write (`dir_i`=1) whose write page lies in 0x200-0x3FF raises `addr_err_o`.
- R12: At a clock edge with `req_i`=1 and no error, only the page register selected by `dir_i` takes `page_upd_o`. An access that raises an error changes no page register.
- R13: `pg_ld_i` loads `pg_val_i` into the read page (`pg_sel_i`=0) or the write page (`pg_sel_i`=1). The load takes priority over an access commit to the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pg_ld_i | input | 1 | Load a page register |
| pg_sel_i | input | 1 | Load target: 0 read page, 1 write page |
| pg_val_i | input | 10 | Page value to load |
| req_i | input | 1 | Commit the access's page update at the edge |
| dir_i | input | 1 | Access direction: 0 read, 1 write |
| mode_i | input | 2 | Bit 0 post-modify, bit 1 decrement |
| wrap_i | input | 1 | Wrapping mode: never changes page |
| byte_i | input | 1 | Byte access (step 1), else word (step 2) |
| ptr_i | input | 16 | Pointer before modification |
| ea_o | output | 16 | Effective address of the access |
| page_o | output | 10 | Page used by the access |
| ptr_upd_o | output | 16 | Modified pointer for write-back |
| page_upd_o | output | 10 | Page after modification |
| addr_err_o | output | 1 | Address error |

## Verification
The hardest cases to reach are the range-edge exceptions, because each one needs a specific page value, a pointer sitting one step from the window edge, and a matching direction and step all at once. The bench loads the page register directly, then applies pre- and post-modify accesses with pointers such as 0xFFFE, 0xFFFF and 0x8000. It checks the combinational result first. It then checks the committed page through a later post-modify access, which shows the current page on `page_o`.

// File: rtl/paged_agen_pkg.sv
package paged_agen_pkg;
  localparam int PTR_W  = 16;
  localparam int PAGE_W = 10;

  localparam logic [PAGE_W-1:0] PG_ZERO     = '0;
  localparam logic [PAGE_W-1:0] PG_FIRST    = PAGE_W'(1);
  localparam logic [PAGE_W-1:0] PG_EXT_LAST = PAGE_W'(10'h1FF);
  localparam logic [PAGE_W-1:0] PG_PRG_LO0  = PAGE_W'(10'h200);
  localparam logic [PAGE_W-1:0] PG_PRG_LAST = PAGE_W'(10'h3FF);

  typedef enum logic [1:0] {
    AM_PRE_INC  = 2'b00,
    AM_POST_INC = 2'b01,
    AM_PRE_DEC  = 2'b10,
    AM_POST_DEC = 2'b11
  } am_e;
endpackage

// File: rtl/paged_agen_step.sv
module paged_agen_step
  import paged_agen_pkg::*;
(
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             dec_i,
  input  logic             byte_i,
  output logic [PTR_W-1:0] raw_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [PTR_W-1:0] step;
  logic [PTR_W:0]   sum;
  logic [PTR_W-1:0] dif;

  assign step = byte_i ? PTR_W'(1) : PTR_W'(2);
  assign sum  = {1'b0, ptr_i} + {1'b0, step};
  assign dif  = ptr_i - step;

  assign raw_o = dec_i ? dif : sum[PTR_W-1:0];
  // crossings only count for paged pointers
  assign ovf_o = ptr_i[PTR_W-1] & ~dec_i & sum[PTR_W];
  assign unf_o = ptr_i[PTR_W-1] &  dec_i & ~dif[PTR_W-1];
endmodule

// File: rtl/paged_agen_policy.sv
module paged_agen_policy
  import paged_agen_pkg::*;
(
  input  logic [PAGE_W-1:0] page_i,
  input  logic              dir_i,
  input  logic              wrap_i,
  input  logic              ovf_i,
  input  logic              unf_i,
  output logic [PAGE_W-1:0] page_o,
  output logic              b15_o
);
  always_comb begin
    page_o = page_i;
    b15_o  = 1'b1;
    if (!wrap_i) begin
      if (ovf_i) begin
        if (page_i == PG_EXT_LAST || (!dir_i && page_i == PG_PRG_LAST)) begin
          b15_o = 1'b0;
        end else begin
          page_o = page_i + PAGE_W'(1);
        end
      end else if (unf_i) begin
        if (!dir_i && (page_i == PG_FIRST || page_i == PG_PRG_LO0)) begin
          b15_o = 1'b0;
        end else begin
          page_o = page_i - PAGE_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/paged_agen_regs.sv
module paged_agen_regs
  import paged_agen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              ld_sel_i,
  input  logic [PAGE_W-1:0] ld_val_i,
  input  logic              upd_i,
  input  logic              upd_sel_i,
  input  logic [PAGE_W-1:0] upd_val_i,
  output logic [PAGE_W-1:0] rd_page_o,
  output logic [PAGE_W-1:0] wr_page_o
);
  logic [PAGE_W-1:0] q [2];

  for (genvar g = 0; g < 2; g++) begin : g_pg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q[g] <= PG_FIRST;
      end else if (ld_i && ld_sel_i == 1'(g)) begin
        q[g] <= ld_val_i;
      end else if (upd_i && upd_sel_i == 1'(g)) begin
        q[g] <= upd_val_i;
      end
    end
  end

  assign rd_page_o = q[0];
  assign wr_page_o = q[1];
endmodule

// File: rtl/paged_agen.sv
module paged_agen
  import paged_agen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pg_ld_i,
  input  logic              pg_sel_i,
  input  logic [9:0]        pg_val_i,
  input  logic              req_i,
  input  logic              dir_i,
  input  logic [1:0]        mode_i,
  input  logic              wrap_i,
  input  logic              byte_i,
  input  logic [15:0]       ptr_i,
  output logic [15:0]       ea_o,
  output logic [9:0]        page_o,
  output logic [15:0]       ptr_upd_o,
  output logic [9:0]        page_upd_o,
  output logic              addr_err_o
);
  logic [PAGE_W-1:0] rd_page_q, wr_page_q, cur_page, nxt_page;
  logic [PTR_W-1:0]  raw;
  logic              ovf, unf, b15, paged, post;

  assign paged    = ptr_i[PTR_W-1];
  assign post     = mode_i[0];
  assign cur_page = dir_i ? wr_page_q : rd_page_q;

  paged_agen_step u_step (
    .ptr_i  (ptr_i),
    .dec_i  (mode_i[1]),
    .byte_i (byte_i),
    .raw_o  (raw),
    .ovf_o  (ovf),
    .unf_o  (unf)
  );

  paged_agen_policy u_policy (
    .page_i (cur_page),
    .dir_i  (dir_i),
    .wrap_i (wrap_i),
    .ovf_i  (ovf),
    .unf_i  (unf),
    .page_o (nxt_page),
    .b15_o  (b15)
  );

  assign ptr_upd_o  = (ovf || unf) ? {b15, raw[PTR_W-2:0]} : raw;
  assign page_upd_o = nxt_page;
  assign ea_o       = post ? ptr_i : ptr_upd_o;
  assign page_o     = post ? cur_page : nxt_page;
  assign addr_err_o = paged && (cur_page == PG_ZERO || (dir_i && cur_page[PAGE_W-1]));

  paged_agen_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (pg_ld_i),
    .ld_sel_i  (pg_sel_i),
    .ld_val_i  (pg_val_i),
    .upd_i     (req_i && !addr_err_o),
    .upd_sel_i (dir_i),
    .upd_val_i (nxt_page),
    .rd_page_o (rd_page_q),
    .wr_page_o (wr_page_q)
  );
endmodule

// File: rtl/paged_agen_chk.sv
module paged_agen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pg_ld_i,
  input logic        req_i,
  input logic        dir_i,
  input logic [1:0]  mode_i,
  input logic        wrap_i,
  input logic [15:0] ptr_i,
  input logic [15:0] ea_o,
  input logic [9:0]  page_o,
  input logic [15:0] ptr_upd_o,
  input logic [9:0]  page_upd_o,
  input logic        addr_err_o,
  input logic [9:0]  rd_page_q,
  input logic [9:0]  wr_page_q
);
  logic [9:0] cur;
  assign cur = dir_i ? wr_page_q : rd_page_q;

  assert_base_no_page_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ptr_i[15] |-> (page_upd_o == cur && !addr_err_o));

  assert_post_orig_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[0] |-> (ea_o == ptr_i && page_o == cur));

  assert_wrap_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && ptr_i[15]) |-> (page_upd_o == cur && ptr_upd_o[15]));

  assert_err_paged_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> ptr_i[15]);

  assert_wr_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i && ptr_i[15] && !addr_err_o) |-> page_upd_o <= 10'h1FF);

  assert_commit_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !addr_err_o && !pg_ld_i) |=>
      (($past(dir_i) ? wr_page_q : rd_page_q) == $past(page_upd_o)));

  assert_err_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_err_o && !pg_ld_i) |=> ($stable(rd_page_q) && $stable(wr_page_q)));
endmodule

bind paged_agen paged_agen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pg_ld_i    (pg_ld_i),
  .req_i      (req_i),
  .dir_i      (dir_i),
  .mode_i     (mode_i),
  .wrap_i     (wrap_i),
  .ptr_i      (ptr_i),
  .ea_o       (ea_o),
  .page_o     (page_o),
  .ptr_upd_o  (ptr_upd_o),
  .page_upd_o (page_upd_o),
  .addr_err_o (addr_err_o),
  .rd_page_q  (rd_page_q),
  .wr_page_q  (wr_page_q)
);

// File: tb/paged_agen_tb.sv
module paged_agen_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg_ld = 1'b0, pg_sel = 1'b0;
  logic [9:0]  pg_val = '0;
  logic        req = 1'b0, dir = 1'b0, wrap = 1'b0, byt = 1'b0;
  logic [1:0]  mode = 2'b01;
  logic [15:0] ptr = '0;
  logic [15:0] ea, ptr_upd;
  logic [9:0]  page, page_upd;
  logic        err;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_agen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pg_ld_i(pg_ld), .pg_sel_i(pg_sel), .pg_val_i(pg_val),
    .req_i(req), .dir_i(dir), .mode_i(mode), .wrap_i(wrap), .byte_i(byt), .ptr_i(ptr),
    .ea_o(ea), .page_o(page), .ptr_upd_o(ptr_upd), .page_upd_o(page_upd), .addr_err_o(err)
  );

  task automatic chk(string req_tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  task automatic load(bit sel, logic [9:0] v);
    @(negedge clk);
    req = 0; pg_ld = 1; pg_sel = sel; pg_val = v;
    @(negedge clk);
    pg_ld = 0;
  endtask

  // drive an access without committing; outputs sampled 1ns later
  task automatic look(bit d, logic [1:0] m, bit w, bit b, logic [15:0] p);
    @(negedge clk);
    req = 0; dir = d; mode = m; wrap = w; byt = b; ptr = p;
    #1;
  endtask

  task automatic commit;
    req = 1;
    @(negedge clk);
    req = 0;
  endtask

  task automatic peek_page(string t, bit d, int exp);
    look(d, 2'b01, 0, 0, 16'h1000);
    chk(t, "committed page", int'(page), exp);
  endtask

  task automatic t_reset;
    peek_page("R1", 0, 'h001);
    peek_page("R1", 1, 'h001);
  endtask

  task automatic t_base;
    look(0, 2'b01, 0, 0, 16'h1000);
    chk("R2", "ea", int'(ea), 'h1000);
    chk("R2", "ptr_upd", int'(ptr_upd), 'h1002);
    chk("R2", "err", int'(err), 0);
    look(0, 2'b10, 0, 1, 16'h0000);
    chk("R2", "dec wrap ptr", int'(ptr_upd), 'hFFFF);
    chk("R2", "page", int'(page_upd), 'h001);
  endtask

  task automatic t_ovf_unf;
    load(0, 10'h005);
    look(0, 2'b00, 0, 0, 16'hFFFE);
    chk("R3", "ptr_upd", int'(ptr_upd), 'h8000);
    chk("R3", "page_upd", int'(page_upd), 'h006);
    chk("R5", "pre ea", int'(ea), 'h8000);
    chk("R5", "pre page", int'(page), 'h006);
    commit();
    peek_page("R12", 0, 'h006);
    peek_page("R12", 1, 'h001);
    look(0, 2'b11, 0, 1, 16'h8000);
    chk("R4", "ptr_upd", int'(ptr_upd), 'hFFFF);
    chk("R4", "page_upd", int'(page_upd), 'h005);
    chk("R5", "post ea", int'(ea), 'h8000);
    chk("R5", "post page", int'(page), 'h006);
    look(0, 2'b01, 0, 1, 16'h8000);
    chk("R5", "byte step", int'(ptr_upd), 'h8001);
  endtask

  task automatic t_wrap;
    load(0, 10'h005);
    look(0, 2'b00, 1, 1, 16'hFFFF);
    chk("R6", "ptr_upd", int'(ptr_upd), 'h8000);
    chk("R6", "page", int'(page_upd), 'h005);
    look(0, 2'b10, 1, 0, 16'h8000);
    chk("R6", "dec ptr", int'(ptr_upd), 'hFFFE);
    chk("R6", "dec page", int'(page_upd), 'h005);
  endtask

  task automatic t_edges;
    load(0, 10'h1FF);
    look(0, 2'b00, 0, 0, 16'hFFFE);
    chk("R7", "rd 1FF ptr", int'(ptr_upd), 'h0000);
    chk("R7", "rd 1FF page", int'(page_upd), 'h1FF);
    load(0, 10'h3FF);
    look(0, 2'b00, 0, 1, 16'hFFFF);
    chk("R7", "rd 3FF ptr", int'(ptr_upd), 'h0000);
    chk("R7", "rd 3FF page", int'(page_upd), 'h3FF);
    load(1, 10'h1FF);
    look(1, 2'b01, 0, 0, 16'hFFFE);
    chk("R7", "wr 1FF ptr", int'(ptr_upd), 'h0000);
    chk("R7", "wr 1FF page", int'(page_upd), 'h1FF);
    load(0, 10'h001);
    look(0, 2'b10, 0, 0, 16'h8000);
    chk("R8", "rd 001 ptr", int'(ptr_upd), 'h7FFE);
    chk("R8", "rd 001 page", int'(page_upd), 'h001);
    load(0, 10'h200);
    look(0, 2'b11, 0, 1, 16'h8000);
    chk("R8", "rd 200 ptr", int'(ptr_upd), 'h7FFF);
    chk("R8", "rd 200 page", int'(page_upd), 'h200);
    load(0, 10'h2FF);
    look(0, 2'b00, 0, 0, 16'hFFFE);
    chk("R9", "2FF ovf ptr", int'(ptr_upd), 'h8000);
    chk("R9", "2FF ovf page", int'(page_upd), 'h300);
    commit();
    peek_page("R9", 0, 'h300);
    look(0, 2'b10, 0, 0, 16'h8000);
    chk("R9", "300 unf ptr", int'(ptr_upd), 'hFFFE);
    chk("R9", "300 unf page", int'(page_upd), 'h2FF);
  endtask

  task automatic t_errors;
    load(0, 10'h000);
    look(0, 2'b01, 0, 0, 16'h8100);
    chk("R10", "page0 err", int'(err), 1);
    commit();
    peek_page("R12", 0, 'h000);
    look(0, 2'b01, 0, 0, 16'h0100);
    chk("R10", "page0 base no err", int'(err), 0);
    load(1, 10'h200);
    look(1, 2'b00, 0, 0, 16'hFFFE);
    chk("R11", "wr prog err", int'(err), 1);
    commit();
    peek_page("R12", 1, 'h200);
    look(1, 2'b01, 0, 0, 16'h0200);
    chk("R11", "wr prog base no err", int'(err), 0);
    load(0, 10'h3FF);
    look(0, 2'b01, 0, 0, 16'h9000);
    chk("R11", "rd prog no err", int'(err), 0);
  endtask

  task automatic t_load_prio;
    load(1, 10'h010);
    look(1, 2'b00, 0, 0, 16'hFFFE);
    chk("R3", "wr ovf page", int'(page_upd), 'h011);
    req = 1; pg_ld = 1; pg_sel = 1; pg_val = 10'h0AA;
    @(negedge clk);
    req = 0; pg_ld = 0;
    peek_page("R13", 1, 'h0AA);
    look(1, 2'b00, 0, 0, 16'hFFFE);
    commit();
    peek_page("R12", 1, 'h0AB);
    peek_page("R12", 0, 'h3FF);
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD*3);
        rst_n = 1;
        t_reset();
        t_base();
        t_ovf_unf();
        t_wrap();
        t_edges();
        t_errors();
        t_load_prio();
      end
      begin
        #(CLK_PERIOD*20000);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule